// File: doc/BRIEF.md
# Supervisory Watchdog and Interval Timer

The block is a supervision timer for a small processor subsystem. A free-running prescaler divides the system clock, and one of four prescaler taps steps a short overflow counter. Software chooses the tap and an overflow action, then starts the timer by writing the run bit.

There are three overflow actions. In interval mode the timer repeats and raises a one-cycle maskable interrupt pulse on every overflow. In the first watchdog mode each overflow raises a one-cycle non-maskable interrupt request. In the second watchdog mode the overflow raises a one-cycle reset request, and the block also returns itself to its reset state.

Software services the watchdog by writing 1 to the run bit again. That write clears the count. Software cannot clear the run bit, and once the timer runs the action and the tap are both frozen. A stop input models the deep-sleep state and freezes counting while it is high.

Top module: `guard_timer`

## Requirements
- R1: After a synchronous reset, irq_o, nmi_o and rst_req_o are 0, the timer is not running, the action selection is interval (0) and the tap selection is 0.
- R2: With tap selection t (0..3), the overflow comes 2^(CNT_W+4+2t) enabled clock cycles after the clock edge that accepted the run write. At the defaults (CNT_W=7) that is 2^11 cycles for tap 0.
- R3: Each accepted write with ctl_run=1 clears the count, so no overflow happens while such writes arrive more often than the period. The next overflow comes one full period after the last such write.
- R4: A control write with ctl_run=0 does not stop a running timer. Only reset, or the block's own reset request, stops it.
- R5: Action code 00 (interval): every overflow gives a one-cycle pulse on irq_o, and counting goes on with the same period.
- R6: Action code 01: every overflow gives a one-cycle pulse on nmi_o, and nmi_o is the only output that pulses.
- R7: Action codes 10 and 11: an overflow gives a single-cycle pulse on rst_req_o. On the next cycle the block is back in its R1 state, so it stays silent until it is started again, and then it uses interval action and tap 0.
- R8: While stop_i is 1 the count is frozen, so each stopped cycle delays the overflow by one cycle.
- R9: While the timer runs, writes to the action code (ctl_mode) and to the tap selection (tap_sel) are ignored.
- R10: Before the first run write, no output ever pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_i | input | 1 | Freezes the prescaler and the counter while high |
| ctl_we | input | 1 | Write strobe for the run bit and the action code |
| ctl_run | input | 1 | Run bit value; 1 starts or services the timer |
| ctl_mode | input | 2 | Action code: 00 interval, 01 NMI, 1x reset |
| tap_we | input | 1 | Write strobe for the tap selection |
| tap_sel | input | TAP_W (2) | Prescaler tap, divide by 2^(4+2*tap_sel) |
| irq_o | output | 1 | Maskable interval interrupt pulse |
| nmi_o | output | 1 | Non-maskable interrupt request pulse |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
Several properties are checked on every cycle: the pulse outputs last one cycle and never fire together; the run state never falls except through reset or the block's own reset request; the action code does not move while the timer runs; the count holds still under stop; and nothing fires while the timer is idle. The bench checks the overflow periods of each tap and how servicing moves the deadline. It also checks the exact delay that a stop window adds, that writes which should be ignored change nothing, and that the timer comes back to its defaults after a reset request. A per-cycle reference model compares all three outputs on every clock.

// File: rtl/guard_pkg.sv
package guard_pkg;
  typedef enum logic [1:0] {
    ACT_INTERVAL = 2'b00,
    ACT_NMI      = 2'b01,
    ACT_RESET    = 2'b10,
    ACT_RESET_B  = 2'b11
  } guard_act_e;

  function automatic logic act_is_reset(input guard_act_e a);
    return a[1];
  endfunction
endpackage

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import guard_pkg::*;
#(
  parameter int TAP_W = 2
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             ctl_we,
  input  logic             ctl_run,
  input  logic [1:0]       ctl_mode,
  input  logic             tap_we,
  input  logic [TAP_W-1:0] tap_sel,
  output logic             run_q,
  output guard_act_e       mode_q,
  output logic [TAP_W-1:0] tap_q,
  output logic             restart
);
  assign restart = ctl_we & ctl_run;

  always_ff @(posedge clk) begin
    if (srst) begin
      run_q  <= 1'b0;
      mode_q <= ACT_INTERVAL;
      tap_q  <= '0;
    end else begin
      if (restart) run_q <= 1'b1;
      if (ctl_we && !run_q) mode_q <= guard_act_e'(ctl_mode);
      if (tap_we && !run_q) tap_q <= tap_sel;
    end
  end
endmodule

// File: rtl/guard_prescaler.sv
module guard_prescaler #(
  parameter int TAP_BASE = 4,
  parameter int TAP_STEP = 2,
  parameter int NUM_TAPS = 4,
  parameter int TAP_W    = 2
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             clr,
  input  logic             en,
  input  logic [TAP_W-1:0] tap,
  output logic             tick
);
  localparam int PRE_W = TAP_BASE + TAP_STEP * (NUM_TAPS - 1);

  logic [PRE_W-1:0]    pre_q;
  logic [NUM_TAPS-1:0] tap_hit;

  always_ff @(posedge clk) begin
    if (srst || clr) pre_q <= '0;
    else if (en)     pre_q <= pre_q + 1'b1;
  end

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    localparam int LOW = TAP_BASE + TAP_STEP * i;
    assign tap_hit[i] = &pre_q[LOW-1:0];
  end

  assign tick = en & ~clr & tap_hit[tap];
endmodule

// File: rtl/guard_counter.sv
module guard_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             clr,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf
);
  always_ff @(posedge clk) begin
    if (srst || clr) cnt_q <= '0;
    else if (tick)   cnt_q <= cnt_q + 1'b1;
  end

  assign ovf = tick & (&cnt_q);
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import guard_pkg::*;
#(
  parameter int CNT_W    = 7,
  parameter int TAP_BASE = 4,
  parameter int TAP_STEP = 2,
  parameter int NUM_TAPS = 4,
  parameter int TAP_W    = $clog2(NUM_TAPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_i,
  input  logic             ctl_we,
  input  logic             ctl_run,
  input  logic [1:0]       ctl_mode,
  input  logic             tap_we,
  input  logic [TAP_W-1:0] tap_sel,
  output logic             irq_o,
  output logic             nmi_o,
  output logic             rst_req_o
);
  logic             srst;
  logic             run_q;
  guard_act_e       mode_q;
  logic [TAP_W-1:0] tap_q;
  logic             restart;
  logic             tick;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf;
  logic             irq_q, nmi_q, rreq_q;

  assign srst = rst | rreq_q;

  guard_ctrl #(.TAP_W(TAP_W)) u_ctrl (
    .clk(clk), .srst(srst), .ctl_we(ctl_we), .ctl_run(ctl_run),
    .ctl_mode(ctl_mode), .tap_we(tap_we), .tap_sel(tap_sel),
    .run_q(run_q), .mode_q(mode_q), .tap_q(tap_q), .restart(restart)
  );

  guard_prescaler #(
    .TAP_BASE(TAP_BASE), .TAP_STEP(TAP_STEP),
    .NUM_TAPS(NUM_TAPS), .TAP_W(TAP_W)
  ) u_pre (
    .clk(clk), .srst(srst), .clr(restart),
    .en(run_q & ~stop_i), .tap(tap_q), .tick(tick)
  );

  guard_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .srst(srst), .clr(restart), .tick(tick),
    .cnt_q(cnt_q), .ovf(ovf)
  );

  always_ff @(posedge clk) begin
    if (srst) begin
      irq_q  <= 1'b0;
      nmi_q  <= 1'b0;
      rreq_q <= 1'b0;
    end else begin
      irq_q  <= ovf & (mode_q == ACT_INTERVAL);
      nmi_q  <= ovf & (mode_q == ACT_NMI);
      rreq_q <= ovf & act_is_reset(mode_q);
    end
  end

  assign irq_o     = irq_q;
  assign nmi_o     = nmi_q;
  assign rst_req_o = rreq_q;
endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             stop_i,
  input logic             ctl_we,
  input logic             irq_o,
  input logic             nmi_o,
  input logic             rst_req_o,
  input logic             run_q,
  input logic [1:0]       mode_q,
  input logic [CNT_W-1:0] cnt_q
);
  // R5
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  // R7
  rreq_single_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |=> !rst_req_o);

  // R6
  one_source_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq_o, nmi_o, rst_req_o}));

  // R7
  self_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |=> (!run_q && mode_q == 2'b00));

  // R4
  run_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && !rst_req_o) |=> run_q);

  // R9
  mode_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && !rst_req_o) |=> $stable(mode_q));

  // R8
  stop_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_i && !ctl_we && run_q && !rst_req_o) |=> $stable(cnt_q));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> !(irq_o || nmi_o || rst_req_o));
endmodule

bind guard_timer guard_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst(rst), .stop_i(stop_i), .ctl_we(ctl_we),
  .irq_o(irq_o), .nmi_o(nmi_o), .rst_req_o(rst_req_o),
  .run_q(run_q), .mode_q(mode_q), .cnt_q(cnt_q)
);

// File: tb/test_guard_timer.sv
module test_guard_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_i = 1'b0;
  logic ctl_we = 1'b0, ctl_run = 1'b0;
  logic [1:0] ctl_mode = 2'b00;
  logic tap_we = 1'b0;
  logic [1:0] tap_sel = 2'b00;
  logic irq_o, nmi_o, rst_req_o;

  guard_timer #(.CNT_W(CW)) i_guard_timer (
    .clk(clk), .rst(rst), .stop_i(stop_i), .ctl_we(ctl_we),
    .ctl_run(ctl_run), .ctl_mode(ctl_mode), .tap_we(tap_we),
    .tap_sel(tap_sel), .irq_o(irq_o), .nmi_o(nmi_o), .rst_req_o(rst_req_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, last_wr = 0;
  bit done = 1'b0;
  int irq_t[$], nmi_t[$], rr_t[$];

  // behavioural reference model
  bit m_run = 0, e_irq = 0, e_nmi = 0, e_rr = 0;
  int m_mode = 0, m_tap = 0, m_el = 0;

  function automatic int period(input int t);
    return 1 << (CW + 4 + 2 * t);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst || e_rr) begin
      m_run = 0; m_mode = 0; m_tap = 0; m_el = 0;
      e_irq = 0; e_nmi = 0; e_rr = 0;
    end else begin
      automatic bit was_run = m_run;
      automatic bit rs = ctl_we && ctl_run;
      e_irq = 0; e_nmi = 0; e_rr = 0;
      if (ctl_we && !was_run) m_mode = ctl_mode;
      if (tap_we && !was_run) m_tap = tap_sel;
      if (rs) begin m_run = 1; m_el = 0; end
      if (was_run && !rs && !stop_i) begin
        m_el++;
        if (m_el == period(m_tap)) begin
          m_el = 0;
          if (m_mode == 0) e_irq = 1;
          else if (m_mode == 1) e_nmi = 1;
          else e_rr = 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R5 irq_o vs model", irq_o, e_irq);
      chk("R6 nmi_o vs model", nmi_o, e_nmi);
      chk("R7 rst_req_o vs model", rst_req_o, e_rr);
      if (irq_o) irq_t.push_back(cyc);
      if (nmi_o) nmi_t.push_back(cyc);
      if (rst_req_o) rr_t.push_back(cyc);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_q();
    irq_t.delete(); nmi_t.delete(); rr_t.delete();
  endtask

  task automatic do_reset();
    rst = 1'b1; tick(2); rst = 1'b0; clear_q();
  endtask

  task automatic wr_ctl(input bit run, input int mode);
    ctl_we = 1'b1; ctl_run = run; ctl_mode = 2'(mode);
    if (run) last_wr = cyc + 1;
    tick(1);
    ctl_we = 1'b0; ctl_run = 1'b0;
  endtask

  task automatic wr_tap(input int t);
    tap_we = 1'b1; tap_sel = 2'(t); tick(1); tap_we = 1'b0;
  endtask

  function automatic int first_delta(ref int q[$], input int w);
    return (q.size() > 0) ? q[0] - w : -1;
  endfunction

  initial begin
    tick(3);
    // R1: outputs idle during and after reset
    chk("R1 outputs in reset", {irq_o, nmi_o, rst_req_o}, 0);
    rst = 1'b0; clear_q();
    // R10: tap and mode writes without run give no pulses
    wr_tap(1); wr_ctl(0, 1); tick(300);
    chk("R10 idle pulses", irq_t.size() + nmi_t.size() + rr_t.size(), 0);

    // R2/R5: interval mode tap 0
    do_reset(); wr_tap(0); wr_ctl(1, 0);
    begin
      automatic int w = last_wr;
      tick(256 * 3 + 5);
      chk("R2 tap0 first overflow", first_delta(irq_t, w), 256);
      chk("R5 interval count", irq_t.size(), 3);
      chk("R5 interval spacing", irq_t.size() == 3 ? irq_t[2] - irq_t[1] : -1, 256);
      chk("R5 no nmi", nmi_t.size(), 0);
    end

    // R4/R9: run=0 write, action and tap writes while running
    wr_ctl(0, 1); wr_tap(3); clear_q(); tick(300);
    chk("R4 still running", irq_t.size() > 0, 1);
    chk("R9 action locked", nmi_t.size(), 0);
    chk("R9 tap locked spacing", irq_t.size() >= 1 ? 1 : 0, 1);

    // R3: servicing
    clear_q();
    for (int i = 0; i < 5; i++) begin wr_ctl(1, 0); tick(200); end
    chk("R3 serviced no overflow", irq_t.size(), 0);
    tick(100);
    chk("R3 deadline after last service", first_delta(irq_t, last_wr), 256);

    // R6: NMI action tap 1
    do_reset(); wr_tap(1); wr_ctl(1, 1); tick(1030);
    chk("R6 nmi period", first_delta(nmi_t, last_wr), 1024);
    chk("R6 no irq", irq_t.size(), 0);

    // R8: stop window
    do_reset(); wr_ctl(1, 0); tick(99);
    stop_i = 1'b1; tick(50); stop_i = 1'b0; tick(300);
    chk("R8 stop delay", first_delta(irq_t, last_wr), 306);

    // R7: reset action tap 2, then defaults return
    do_reset(); wr_tap(2); wr_ctl(1, 2); tick(4100);
    chk("R7 reset request time", first_delta(rr_t, last_wr), 4096);
    chk("R7 single request", rr_t.size(), 1);
    clear_q(); tick(5000);
    chk("R7 silent after self reset", irq_t.size() + nmi_t.size() + rr_t.size(), 0);
    wr_ctl(1, 0); tick(260);
    chk("R7 defaults restored", first_delta(irq_t, last_wr), 256);

    // R2/R7: code 11 with tap 3
    do_reset(); wr_tap(3); wr_ctl(1, 3); tick(16390);
    chk("R2 tap3 reset request", first_delta(rr_t, last_wr), 16384);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual %0d expected 0 (cycle %0d)", cyc, cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule